// File: doc/BRIEF.md
# E1 Line Channel Loopback and Output Control

This block sits between the digital framer side and the line driver/receiver of one E1 channel. It picks which rail pair drives the transmit line: framer data, received data looped back, or a generated all-ones pattern. It also picks which rail pair and strobe appear on the receive-side outputs: line data, or framer data looped back. On top of that choice it applies forcing rules in a fixed order. Power down comes first, then all-ones, then transmit-clock loss. Loss-of-signal squelching acts on the receive outputs.

All logic runs on one fast system clock. Each of the three bit clocks (transmit, recovered, master) arrives as a one-cycle strobe in that clock domain. When the all-ones pattern is sent while the transmit clock is lost, the pattern is stepped by the master-clock strobe instead of the transmit strobe. Outputs are registered and change on the system clock edge at which the causing input is sampled.

Top module: `e1_loopback_ctrl`

## Requirements
- R1: In normal mode (loop code 00), with no forcing condition present, each cycle with `tx_stb`=1 loads `{line_p,line_n}` from `{tx_pos,tx_neg}`. The line outputs hold their value in cycles without `tx_stb`.
- R2: With `pol_n`=1 a rail value of 1 becomes a mark (line output 1). With `pol_n`=0 a rail value of 0 becomes a mark, so each line output is the inverse of its rail.
- R3: Loop code 01 (local loopback) loads `{rx_out_pos,rx_out_neg}` from the transmit rails on `tx_stb`, and `rx_out_stb` follows `tx_stb` one cycle later. The line receive rails and `rx_stb` are ignored. The line outputs still carry transmit data as in R1.
- R4: Loop code 10 (remote loopback) loads the line outputs from `{rx_pos,rx_neg}` on `rx_stb`, with polarity applied as in R2. The transmit rails, `tx_stb` and `txclk_lost` have no effect. The receive outputs behave normally.
- R5: Loop code 11 is treated as normal mode, and `lb_inhibit` is 1 in the cycle after the code is sampled. `lb_inhibit` is 0 after any other code.
- R6: With `all_ones`=1, each timing tick drives one mark on alternating rails, starting with `line_p`. The first tick after `all_ones` rises gives `{1,0}`, the next gives `{0,1}`, and so on. This overrides remote-loopback data. Polarity does not apply to it.
- R7: With `all_ones`=1 and `txclk_lost`=1, the timing tick is `ref_stb` and `tx_stb` is ignored.
- R8: With `txclk_lost`=1, `all_ones`=0 and a loop code other than 10, both line outputs go to 0 at the next edge.
- R9: With `pwr_dn`=1, both line outputs go to 0 and `los_out` goes to 1 at the next edge. This takes priority over all-ones.
- R10: When `los_in` or `pwr_dn` is 1 and `squelch_dis` is 0, the receive rail outputs go to 0 at the next edge. With `squelch_dis`=1 the selected data passes unchanged.
- R11: While `rst_n`=0: line outputs are 0, receive rail outputs and `rx_out_stb` are 0, `los_out` is 1, and `lb_inhibit` is 0.
- R12: `los_out` is the registered OR of `los_in` and `pwr_dn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_pos | input | 1 | Transmit positive rail from framer |
| tx_neg | input | 1 | Transmit negative rail from framer |
| tx_stb | input | 1 | Transmit bit-clock strobe |
| rx_pos | input | 1 | Received positive rail from line receiver |
| rx_neg | input | 1 | Received negative rail from line receiver |
| rx_stb | input | 1 | Recovered bit-clock strobe |
| ref_stb | input | 1 | Master-clock bit strobe |
| los_in | input | 1 | Loss-of-signal indication |
| txclk_lost | input | 1 | Transmit clock missing |
| lb_mode | input | 2 | Loop code {remote, local} |
| all_ones | input | 1 | Send all-ones pattern |
| pol_n | input | 1 | Rail polarity select |
| pwr_dn | input | 1 | Channel power down |
| squelch_dis | input | 1 | Disable receive squelch on LOS |
| line_p | output | 1 | Transmit line positive mark |
| line_n | output | 1 | Transmit line negative mark |
| rx_out_pos | output | 1 | Receive positive rail output |
| rx_out_neg | output | 1 | Receive negative rail output |
| rx_out_stb | output | 1 | Receive bit strobe output |
| los_out | output | 1 | Registered loss-of-signal |
| lb_inhibit | output | 1 | Illegal loop code flagged |

## Verification
The bench drives transmit-clock loss during remote loopback. A design that forced the line idle there would break the loop, since that path never uses the transmit clock. It turns on all-ones during remote loopback, and an ordering error would leak received data onto the line. It drops the transmit clock while all-ones runs, to catch a pattern that stalls instead of moving to master timing. It holds the strobes low for a cycle to catch outputs that fail to hold, and it feeds receive-side data during local loopback to catch a receive path that is not fully isolated.

// File: rtl/e1_loopback_ctrl.sv
module e1_loopback_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_pos,
  input  logic       tx_neg,
  input  logic       tx_stb,
  input  logic       rx_pos,
  input  logic       rx_neg,
  input  logic       rx_stb,
  input  logic       ref_stb,
  input  logic       los_in,
  input  logic       txclk_lost,
  input  logic [1:0] lb_mode,
  input  logic       all_ones,
  input  logic       pol_n,
  input  logic       pwr_dn,
  input  logic       squelch_dis,
  output logic       line_p,
  output logic       line_n,
  output logic       rx_out_pos,
  output logic       rx_out_neg,
  output logic       rx_out_stb,
  output logic       los_out,
  output logic       lb_inhibit
);

  localparam logic [1:0] LB_LOCAL  = 2'b01;
  localparam logic [1:0] LB_REMOTE = 2'b10;
  localparam logic [1:0] LB_BAD    = 2'b11;

  logic local_lb, remote_lb, los_eff, ao_tick, ao_phase;
  logic src_p, src_n, src_stb;
  logic rsel_p, rsel_n, rsel_stb;

  assign local_lb  = (lb_mode == LB_LOCAL);
  assign remote_lb = (lb_mode == LB_REMOTE);
  assign los_eff   = los_in | pwr_dn;
  assign ao_tick   = txclk_lost ? ref_stb : tx_stb;

  assign src_p   = remote_lb ? rx_pos : tx_pos;
  assign src_n   = remote_lb ? rx_neg : tx_neg;
  assign src_stb = remote_lb ? rx_stb : tx_stb;

  assign rsel_p   = local_lb ? tx_pos : rx_pos;
  assign rsel_n   = local_lb ? tx_neg : rx_neg;
  assign rsel_stb = local_lb ? tx_stb : rx_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_p   <= 1'b0;
      line_n   <= 1'b0;
      ao_phase <= 1'b0;
    end else if (pwr_dn) begin
      line_p   <= 1'b0;
      line_n   <= 1'b0;
      ao_phase <= 1'b0;
    end else if (all_ones) begin
      if (ao_tick) begin
        line_p   <= ~ao_phase;
        line_n   <= ao_phase;
        ao_phase <= ~ao_phase;
      end
    end else begin
      ao_phase <= 1'b0;
      if (txclk_lost && !remote_lb) begin
        line_p <= 1'b0;
        line_n <= 1'b0;
      end else if (src_stb) begin
        line_p <= ~(src_p ^ pol_n);
        line_n <= ~(src_n ^ pol_n);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_out_pos <= 1'b0;
      rx_out_neg <= 1'b0;
      rx_out_stb <= 1'b0;
      los_out    <= 1'b1;
      lb_inhibit <= 1'b0;
    end else begin
      rx_out_stb <= rsel_stb;
      los_out    <= los_eff;
      lb_inhibit <= (lb_mode == LB_BAD);
      if (los_eff && !squelch_dis) begin
        rx_out_pos <= 1'b0;
        rx_out_neg <= 1'b0;
      end else if (rsel_stb) begin
        rx_out_pos <= rsel_p;
        rx_out_neg <= rsel_n;
      end
    end
  end

  AST_PWRDN_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!line_p && !line_n)); // R9
  AST_PWRDN_LOS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> los_out); // R9
  AST_SQUELCH_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (los_eff && !squelch_dis) |=> (!rx_out_pos && !rx_out_neg)); // R10
  AST_TXLOST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (txclk_lost && !all_ones && !pwr_dn && !remote_lb) |=> (!line_p && !line_n)); // R8
  AST_BAD_CODE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_mode == LB_BAD) |=> lb_inhibit); // R5
  AST_LOCAL_STB: assert property (@(posedge clk) disable iff (!rst_n)
    local_lb |=> (rx_out_stb == $past(tx_stb))); // R3

endmodule

// File: tb/e1_loopback_ctrl_bench.sv
module e1_loopback_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_pos = 0, tx_neg = 0, tx_stb = 0, rx_pos = 0, rx_neg = 0, rx_stb = 0, ref_stb = 0;
  logic los_in = 0, txclk_lost = 0, all_ones = 0, pol_n = 1, pwr_dn = 0, squelch_dis = 0;
  logic [1:0] lb_mode = 2'b00;
  logic line_p, line_n, rx_out_pos, rx_out_neg, rx_out_stb, los_out, lb_inhibit;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  e1_loopback_ctrl u_e1_loopback_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_pos(tx_pos), .tx_neg(tx_neg), .tx_stb(tx_stb),
    .rx_pos(rx_pos), .rx_neg(rx_neg), .rx_stb(rx_stb), .ref_stb(ref_stb),
    .los_in(los_in), .txclk_lost(txclk_lost), .lb_mode(lb_mode), .all_ones(all_ones),
    .pol_n(pol_n), .pwr_dn(pwr_dn), .squelch_dis(squelch_dis),
    .line_p(line_p), .line_n(line_n), .rx_out_pos(rx_out_pos), .rx_out_neg(rx_out_neg),
    .rx_out_stb(rx_out_stb), .los_out(los_out), .lb_inhibit(lb_inhibit)
  );

  // lb(2)_ao pol pd sqd_lost los_tp tn ts_rp rn rs_ref__lp ln rop ron rstb los inh
  localparam int NV = 21;
  localparam logic [21:0] VEC [NV] = '{
    22'b00_0100_00_101_011_0_1001100,
    22'b00_0100_00_010_000_0_1001000,
    22'b00_0000_00_011_000_0_1001000,
    22'b00_0000_00_111_000_0_0001000,
    22'b01_0100_00_011_111_0_0101100,
    22'b01_0100_00_100_101_0_0101000,
    22'b10_0100_00_111_101_0_1010100,
    22'b10_0100_00_011_000_0_1010000,
    22'b10_0100_10_000_011_0_0101100,
    22'b11_0100_00_101_111_0_1011101,
    22'b00_1100_00_001_000_0_1011000,
    22'b00_1100_00_000_000_0_1011000,
    22'b00_1100_00_001_000_0_0111000,
    22'b10_1100_00_001_001_0_1000100,
    22'b00_1100_10_001_000_0_1000000,
    22'b00_1100_10_000_000_1_0100000,
    22'b00_0100_10_101_000_0_0000000,
    22'b00_1110_00_001_111_0_0000110,
    22'b00_0100_01_101_101_0_1000110,
    22'b00_0101_01_000_101_0_1010110,
    22'b00_0100_00_000_000_0_1010000
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1:           return "R1";
      2, 3:           return "R2";
      4, 5:           return "R3";
      6, 7, 8:        return "R4";
      9:              return "R5";
      10, 11, 12, 13: return "R6";
      14, 15:         return "R7";
      16:             return "R8";
      17:             return "R9";
      18, 19:         return "R10";
      default:        return "R12";
    endcase
  endfunction

  task automatic check(string req, logic [6:0] exp);
    logic [6:0] act;
    act = {line_p, line_n, rx_out_pos, rx_out_neg, rx_out_stb, los_out, lb_inhibit};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic apply(logic [14:0] v);
    {lb_mode, all_ones, pol_n, pwr_dn, squelch_dis, txclk_lost, los_in,
     tx_pos, tx_neg, tx_stb, rx_pos, rx_neg, rx_stb, ref_stb} = v;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #500us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R11", 7'b0000010);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][21:7]);
      @(posedge clk);
      @(negedge clk);
      check(tag_of(i), VEC[i][6:0]);
    end
    // R11: reset mid-run with active data and illegal code present
    apply(15'b11_0100_00_111_111_1);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R11", 7'b0000010);
    // R5: flag rises once reset is released with code 11 held; line follows R1 data
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R5", 7'b1111101);
    done = 1;
    finish_run();
  end

endmodule